// File: doc/BRIEF.md
# Framebuffer Pixel Write Engine

This block sits between a host data port and a byte-per-pixel on-chip pixel memory. Each host data write of 1, 2 or 4 bytes is turned into a short burst of single-byte pixel writes. The pattern of that burst is set by a 16-bit mode code, which is held in the upper half of a destination access register. Some modes store four bytes, either at a linear byte offset with the bytes swapped or at an offset mapped from x/y coordinates. Other modes expand each data bit into a whole pixel: a set bit gives the foreground colour and a clear bit gives the background colour, or a plain 1/0.

Pixel writes can be gated per pixel by a bitmask register, and background pixels can be made transparent. Both are controlled by flags in an image operation register. For each host write, the block also returns the position the host should use for the next one. The step depends on the mode. Pixels are issued one per clock. While a burst is in flight the block raises `busy`, and the host holds off further data writes until it falls.

A small register port loads the following:

| Select code | Register |
|---|---|
| 0 | destination and source access together |
| 1 | destination access |
| 2 | source access |
| 3 | image operation |
| 4 | bitmask |
| 5 | foreground colour |
| 6 | background colour |
| 7 | plane mask |

Top module: `fbw_engine`

## Requirements
- R1: After reset, `busy`, `pix_we` and `pos_vld` are 0 and `plane_mask` is 0xFF. The image operation register resets to 0x23000300, so bitmask gating is on and transparency is off. The bitmask resets to all ones.
- R2: Mode codes 0x3BA0 and 0xBBE0 store four bytes at byte offsets pos+0..pos+3. The data is byte-swapped first, so data[7:0] lands at pos+0 and data[31:24] at pos+3. The returned position is pos+4.
- R3: Mode 0x1360 stores data[31:24] at off+0 down to data[7:0] at off+3. Here off = (pos >> 10) * FB_WIDTH + pos[9:0]. The returned position is pos+4.
- R4: Mode 0x13A0 stores the same way as R3, but computes off from pos >> 2. The returned position is pos+16.
- R5: Mode 0x2EA0 expands n = 8*size data bits (size 1 or 2; any other size counts as 4) into n pixels, most significant bit first. Pixel i goes to off+i, with off computed from pos >> 2. A set bit writes the foreground colour (register bits 7:0) and a clear bit writes the background colour. The returned position is pos+4.
- R6: Mode 0x28A0 behaves as R5 but writes the value 1 for set bits and 0 for clear bits.
- R7: While image operation bit 29 is set, pixel i of a burst (byte i in store modes, bit i counted from the MSB in expansion modes) is written only if bitmask bit 31-i is set.
- R8: In expansion modes, clear-bit pixels are not written when image operation bit 28 or bit 1 is set.
- R9: A write with select 0 loads both the destination and the source access registers. Select 1 leaves the source register unchanged. The source register is visible on `src_access`.
- R10: Any other mode code writes no pixel and returns the position unchanged.
- R11: A pixel whose offset is at or beyond FB_WIDTH*FB_HEIGHT is dropped. Pixels in range are written with plain replace.
- R12: An accepted data write gives `pos_vld` with `pos_next` on the next cycle. `busy` then stays high for exactly one cycle per pixel slot (4 for store modes, n for expansion modes). Each slot presents at most one memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | register write strobe |
| reg_sel | input | 3 | register select code (see table above) |
| reg_wdata | input | 32 | register write value |
| dat_we | input | 1 | data write strobe, accepted when `busy` is low |
| dat_addr | input | 32 | write position |
| dat_size | input | 3 | access size in bytes (1, 2 or 4) |
| dat_wdata | input | 32 | write data, right-aligned |
| busy | output | 1 | pixel burst in progress |
| pos_vld | output | 1 | `pos_next` valid pulse |
| pos_next | output | 32 | advanced write position |
| src_access | output | 32 | source access register, for the read path |
| plane_mask | output | 32 | plane mask register |
| pix_we | output | 1 | pixel memory write enable |
| pix_addr | output | AW | pixel memory byte address |
| pix_data | output | 8 | pixel value |

## Verification
The checker assumes the host never raises `dat_we` while `busy` is high. It also assumes `dat_size` stays at 1, 2 or 4. The properties on position timing and slot pacing are written on that basis. The stimulus keeps within these limits by polling `busy` at the falling edge before every data write and by drawing sizes only from that set. Positions are built from coordinates that lie partly off the bottom and right of the buffer, so out-of-range drops are covered without ever violating the input contract.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  // Mode codes held in the upper half of the destination access register
  localparam logic [15:0] MODE_LIN_SWAP_A = 16'h3ba0;
  localparam logic [15:0] MODE_LIN_SWAP_B = 16'hbbe0;
  localparam logic [15:0] MODE_XY_RAW     = 16'h1360;
  localparam logic [15:0] MODE_XY_WORD    = 16'h13a0;
  localparam logic [15:0] MODE_EXP_COLOR  = 16'h2ea0;
  localparam logic [15:0] MODE_EXP_MONO   = 16'h28a0;

  // Register select codes
  localparam logic [2:0] SEL_DST_SRC = 3'd0;
  localparam logic [2:0] SEL_DST     = 3'd1;
  localparam logic [2:0] SEL_SRC     = 3'd2;
  localparam logic [2:0] SEL_IMGOP   = 3'd3;
  localparam logic [2:0] SEL_BITMASK = 3'd4;
  localparam logic [2:0] SEL_FG      = 3'd5;
  localparam logic [2:0] SEL_BG      = 3'd6;
  localparam logic [2:0] SEL_PLANE   = 3'd7;

  // Image operation flag positions
  localparam int IMGOP_GATE_BIT  = 29;
  localparam int IMGOP_TRANSP_HI = 28;
  localparam int IMGOP_TRANSP_LO = 1;

  localparam logic [31:0] IMGOP_RST   = 32'h2300_0300;
  localparam logic [31:0] PLANE_RST   = 32'h0000_00ff;
  localparam logic [31:0] BITMASK_RST = 32'hffff_ffff;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_STORE,
    KIND_EXPAND
  } kind_e;

  // One decoded burst; data and mask are left-aligned, slot 0 at bit 31
  typedef struct packed {
    kind_e       kind;
    logic [31:0] base;
    logic [5:0]  count;
    logic [31:0] data;
    logic [31:0] mask;
    logic [7:0]  fg;
    logic [7:0]  bg;
    logic        gate;
    logic        transp;
  } cmd_t;

endpackage

// File: rtl/fbw_regs.sv
module fbw_regs
  import fbw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [15:0] dst_mode,
  output logic [31:0] src_access,
  output logic        op_gate,
  output logic        op_transp_hi,
  output logic        op_transp_lo,
  output logic [31:0] bitmask,
  output logic [7:0]  fg_color,
  output logic [7:0]  bg_color,
  output logic [31:0] plane_mask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_mode     <= 16'h0000;
      src_access   <= 32'h0;
      op_gate      <= IMGOP_RST[IMGOP_GATE_BIT];
      op_transp_hi <= IMGOP_RST[IMGOP_TRANSP_HI];
      op_transp_lo <= IMGOP_RST[IMGOP_TRANSP_LO];
      bitmask      <= BITMASK_RST;
      fg_color     <= 8'h00;
      bg_color     <= 8'h00;
      plane_mask   <= PLANE_RST;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_DST_SRC: begin
          dst_mode   <= reg_wdata[31:16];
          src_access <= reg_wdata;
        end
        SEL_DST:     dst_mode   <= reg_wdata[31:16];
        SEL_SRC:     src_access <= reg_wdata;
        SEL_IMGOP: begin
          op_gate      <= reg_wdata[IMGOP_GATE_BIT];
          op_transp_hi <= reg_wdata[IMGOP_TRANSP_HI];
          op_transp_lo <= reg_wdata[IMGOP_TRANSP_LO];
        end
        SEL_BITMASK: bitmask    <= reg_wdata;
        SEL_FG:      fg_color   <= reg_wdata[7:0];
        SEL_BG:      bg_color   <= reg_wdata[7:0];
        SEL_PLANE:   plane_mask <= reg_wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fbw_decode.sv
module fbw_decode
  import fbw_pkg::*;
#(
  parameter int FB_WIDTH  = 64,
  parameter int POS_XBITS = 10
) (
  input  logic [15:0] mode,
  input  logic [31:0] pos,
  input  logic [2:0]  size,
  input  logic [31:0] wdata,
  input  logic        op_gate,
  input  logic        op_transp,
  input  logic [31:0] bitmask,
  input  logic [7:0]  fg_color,
  input  logic [7:0]  bg_color,
  output cmd_t        cmd,
  output logic [31:0] next_pos
);

  localparam logic [31:0] XMASK = (32'd1 << POS_XBITS) - 32'd1;
  localparam logic [31:0] WIDTH = 32'(FB_WIDTH);

  function automatic logic [31:0] xy_offset(input logic [31:0] p);
    return (p >> POS_XBITS) * WIDTH + (p & XMASK);
  endfunction

  logic [5:0]  nbits;
  logic [5:0]  lshift;
  logic [31:0] swapped;

  always_comb begin
    case (size)
      3'd1:    nbits = 6'd8;
      3'd2:    nbits = 6'd16;
      default: nbits = 6'd32;
    endcase
    lshift  = 6'd32 - nbits;
    swapped = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
  end

  always_comb begin
    cmd.kind   = KIND_NONE;
    cmd.base   = 32'h0;
    cmd.count  = 6'd4;
    cmd.data   = wdata;
    cmd.mask   = bitmask;
    cmd.fg     = fg_color;
    cmd.bg     = bg_color;
    cmd.gate   = op_gate;
    cmd.transp = op_transp;
    next_pos   = pos;
    case (mode)
      MODE_LIN_SWAP_A, MODE_LIN_SWAP_B: begin
        cmd.kind = KIND_STORE;
        cmd.base = pos;
        cmd.data = swapped;
        next_pos = pos + 32'd4;
      end
      MODE_XY_RAW: begin
        cmd.kind = KIND_STORE;
        cmd.base = xy_offset(pos);
        next_pos = pos + 32'd4;
      end
      MODE_XY_WORD: begin
        cmd.kind = KIND_STORE;
        cmd.base = xy_offset(pos >> 2);
        next_pos = pos + 32'd16;
      end
      MODE_EXP_COLOR, MODE_EXP_MONO: begin
        cmd.kind  = KIND_EXPAND;
        cmd.base  = xy_offset(pos >> 2);
        cmd.count = nbits;
        cmd.data  = wdata << lshift;
        if (mode == MODE_EXP_MONO) begin
          cmd.fg = 8'd1;
          cmd.bg = 8'd0;
        end
        next_pos = pos + 32'd4;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fbw_pixel_seq.sv
module fbw_pixel_seq
  import fbw_pkg::*;
#(
  parameter int MEM_SIZE = 1536,
  parameter int AW       = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  cmd_t          cmd,
  output logic          active,
  output logic          pix_we,
  output logic [AW-1:0] pix_addr,
  output logic [7:0]    pix_data
);

  localparam logic [31:0] LIMIT = 32'(MEM_SIZE);

  kind_e       kind_q;
  logic [31:0] off_q;
  logic [31:0] dsh_q;
  logic [31:0] msh_q;
  logic [5:0]  left_q;
  logic [7:0]  fg_q;
  logic [7:0]  bg_q;
  logic        gate_q;
  logic        transp_q;

  logic        slot_we;
  logic [7:0]  slot_val;
  logic        gate_ok;
  logic        in_range;

  always_comb begin
    gate_ok  = !gate_q || msh_q[31];
    in_range = off_q < LIMIT;
    if (kind_q == KIND_STORE) begin
      slot_val = dsh_q[31:24];
      slot_we  = gate_ok && in_range;
    end else begin
      slot_val = dsh_q[31] ? fg_q : bg_q;
      slot_we  = gate_ok && in_range && (dsh_q[31] || !transp_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      pix_we   <= 1'b0;
      pix_addr <= '0;
      pix_data <= 8'h00;
      kind_q   <= KIND_NONE;
      off_q    <= 32'h0;
      dsh_q    <= 32'h0;
      msh_q    <= 32'h0;
      left_q   <= 6'd0;
      fg_q     <= 8'h00;
      bg_q     <= 8'h00;
      gate_q   <= 1'b0;
      transp_q <= 1'b0;
    end else begin
      pix_we <= 1'b0;
      if (active) begin
        pix_we   <= slot_we;
        pix_addr <= off_q[AW-1:0];
        pix_data <= slot_val;
        off_q    <= off_q + 32'd1;
        msh_q    <= msh_q << 1;
        dsh_q    <= (kind_q == KIND_STORE) ? (dsh_q << 8) : (dsh_q << 1);
        left_q   <= left_q - 6'd1;
        if (left_q == 6'd1) active <= 1'b0;
      end else if (start && cmd.kind != KIND_NONE) begin
        active   <= 1'b1;
        kind_q   <= cmd.kind;
        off_q    <= cmd.base;
        dsh_q    <= cmd.data;
        msh_q    <= cmd.mask;
        left_q   <= cmd.count;
        fg_q     <= cmd.fg;
        bg_q     <= cmd.bg;
        gate_q   <= cmd.gate;
        transp_q <= cmd.transp;
      end
    end
  end

endmodule

// File: rtl/fbw_engine.sv
module fbw_engine
  import fbw_pkg::*;
#(
  parameter int FB_WIDTH  = 64,
  parameter int FB_HEIGHT = 24,
  parameter int POS_XBITS = 10,
  localparam int MEM_SIZE = FB_WIDTH * FB_HEIGHT,
  localparam int AW       = $clog2(MEM_SIZE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          dat_we,
  input  logic [31:0]   dat_addr,
  input  logic [2:0]    dat_size,
  input  logic [31:0]   dat_wdata,
  output logic          busy,
  output logic          pos_vld,
  output logic [31:0]   pos_next,
  output logic [31:0]   src_access,
  output logic [31:0]   plane_mask,
  output logic          pix_we,
  output logic [AW-1:0] pix_addr,
  output logic [7:0]    pix_data
);

  logic [15:0] dst_mode;
  logic        op_gate;
  logic        op_transp_hi;
  logic        op_transp_lo;
  logic [31:0] bitmask;
  logic [7:0]  fg_color;
  logic [7:0]  bg_color;
  cmd_t        cmd;
  logic [31:0] next_pos;
  logic        accept;

  assign accept = dat_we && !busy;

  fbw_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .reg_we       (reg_we),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .dst_mode     (dst_mode),
    .src_access   (src_access),
    .op_gate      (op_gate),
    .op_transp_hi (op_transp_hi),
    .op_transp_lo (op_transp_lo),
    .bitmask      (bitmask),
    .fg_color     (fg_color),
    .bg_color     (bg_color),
    .plane_mask   (plane_mask)
  );

  fbw_decode #(
    .FB_WIDTH  (FB_WIDTH),
    .POS_XBITS (POS_XBITS)
  ) u_decode (
    .mode      (dst_mode),
    .pos       (dat_addr),
    .size      (dat_size),
    .wdata     (dat_wdata),
    .op_gate   (op_gate),
    .op_transp (op_transp_hi | op_transp_lo),
    .bitmask   (bitmask),
    .fg_color  (fg_color),
    .bg_color  (bg_color),
    .cmd       (cmd),
    .next_pos  (next_pos)
  );

  fbw_pixel_seq #(
    .MEM_SIZE (MEM_SIZE),
    .AW       (AW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .cmd      (cmd),
    .active   (busy),
    .pix_we   (pix_we),
    .pix_addr (pix_addr),
    .pix_data (pix_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_vld  <= 1'b0;
      pos_next <= 32'h0;
    end else begin
      pos_vld <= accept;
      if (accept) pos_next <= next_pos;
    end
  end

endmodule

// File: rtl/fbw_engine_chk.sv
module fbw_engine_chk #(
  parameter int MEM_SIZE = 1536,
  parameter int AW       = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [2:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic          dat_we,
  input logic [31:0]   dat_addr,
  input logic          busy,
  input logic          pos_vld,
  input logic [31:0]   pos_next,
  input logic [31:0]   src_access,
  input logic          pix_we,
  input logic [AW-1:0] pix_addr
);

  // Input contract: host waits for busy to fall (R12)
  a_r12_host_waits: assert property (@(posedge clk) disable iff (rst)
    busy |-> !dat_we);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !pix_we && !pos_vld));

  a_r12_pix_in_slot: assert property (@(posedge clk) disable iff (rst)
    pix_we |-> $past(busy));

  a_r12_pos_after_accept: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !busy) |=> pos_vld);

  a_r12_pos_needs_write: assert property (@(posedge clk) disable iff (rst)
    pos_vld |-> $past(dat_we));

  a_r11_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    pix_we |-> (32'(pix_addr) < 32'(MEM_SIZE)));

  a_r9_combined_loads_src: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 3'd0) |=> (src_access == $past(reg_wdata)));

  // R10: step is 0 (unknown mode), 4 or 16
  a_r10_step_legal: assert property (@(posedge clk) disable iff (rst)
    pos_vld |-> ((pos_next - $past(dat_addr)) == 32'd0 ||
                 (pos_next - $past(dat_addr)) == 32'd4 ||
                 (pos_next - $past(dat_addr)) == 32'd16));

endmodule

bind fbw_engine fbw_engine_chk #(
  .MEM_SIZE (MEM_SIZE),
  .AW       (AW)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .dat_we     (dat_we),
  .dat_addr   (dat_addr),
  .busy       (busy),
  .pos_vld    (pos_vld),
  .pos_next   (pos_next),
  .src_access (src_access),
  .pix_we     (pix_we),
  .pix_addr   (pix_addr)
);

// File: tb/fbw_engine_test.sv
module fbw_engine_test;

  localparam int W   = 64;
  localparam int H   = 24;
  localparam int XB  = 10;
  localparam int MEM = W * H;
  localparam int AW  = $clog2(MEM);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [31:0]   reg_wdata = 32'h0;
  logic          dat_we = 1'b0;
  logic [31:0]   dat_addr = 32'h0;
  logic [2:0]    dat_size = 3'd4;
  logic [31:0]   dat_wdata = 32'h0;
  logic          busy;
  logic          pos_vld;
  logic [31:0]   pos_next;
  logic [31:0]   src_access;
  logic [31:0]   plane_mask;
  logic          pix_we;
  logic [AW-1:0] pix_addr;
  logic [7:0]    pix_data;

  fbw_engine #(.FB_WIDTH(W), .FB_HEIGHT(H), .POS_XBITS(XB)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dat_we(dat_we), .dat_addr(dat_addr),
    .dat_size(dat_size), .dat_wdata(dat_wdata), .busy(busy),
    .pos_vld(pos_vld), .pos_next(pos_next), .src_access(src_access),
    .plane_mask(plane_mask), .pix_we(pix_we), .pix_addr(pix_addr),
    .pix_data(pix_data)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  logic [7:0]  exp_mem [MEM];
  logic [7:0]  obs_mem [MEM];
  logic [31:0] b_dst   = 32'h0;
  logic [31:0] b_src   = 32'h0;
  logic [31:0] b_img   = 32'h2300_0300;
  logic [31:0] b_mask  = 32'hffff_ffff;
  logic [7:0]  b_fg    = 8'h00;
  logic [7:0]  b_bg    = 8'h00;

  always @(negedge clk) if (pix_we) obs_mem[pix_addr] = pix_data;

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] xy(input logic [31:0] p);
    return (p >> XB) * 32'(W) + (p & ((32'd1 << XB) - 1));
  endfunction

  task automatic model(input logic [31:0] a, input logic [2:0] sz,
                       input logic [31:0] d, output logic [31:0] np,
                       output int npix);
    logic [15:0] m;
    logic [31:0] base, dd, off;
    logic [7:0]  fgv, bgv, val;
    bit          expand, gate, wr, bitv;
    int          n;
    m = b_dst[31:16];
    np = a; npix = 0; expand = 0; base = 0; dd = d; fgv = b_fg; bgv = b_bg;
    n = (sz == 3'd1) ? 8 : (sz == 3'd2) ? 16 : 32;
    case (m)
      16'h3ba0, 16'hbbe0: begin
        base = a; dd = {d[7:0], d[15:8], d[23:16], d[31:24]};
        np = a + 4; npix = 4;
      end
      16'h1360: begin base = xy(a); np = a + 4; npix = 4; end
      16'h13a0: begin base = xy(a >> 2); np = a + 16; npix = 4; end
      16'h2ea0, 16'h28a0: begin
        expand = 1; base = xy(a >> 2); np = a + 4; npix = n;
        if (m == 16'h28a0) begin fgv = 8'd1; bgv = 8'd0; end
      end
      default: ;
    endcase
    for (int i = 0; i < npix; i++) begin
      off  = base + 32'(i);
      gate = !b_img[29] || b_mask[31 - i];
      if (!expand) begin
        val = dd[31 - 8*i -: 8];
        wr  = gate;
      end else begin
        bitv = d[n - 1 - i];
        val  = bitv ? fgv : bgv;
        wr   = gate && (bitv || !(b_img[28] || b_img[1]));
      end
      if (wr && off < 32'(MEM)) exp_mem[off] = val;
    end
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    case (sel)
      3'd0: begin b_dst = v; b_src = v; end
      3'd1: b_dst = v;
      3'd2: b_src = v;
      3'd3: b_img = v;
      3'd4: b_mask = v;
      3'd5: b_fg = v[7:0];
      3'd6: b_bg = v[7:0];
      default: ;
    endcase
  endtask

  task automatic data_wr(input string req, input logic [31:0] a,
                         input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] np;
    int          npix, cyc, bad;
    model(a, sz, d, np, npix);
    @(negedge clk);
    while (busy) @(negedge clk);
    dat_we = 1'b1; dat_addr = a; dat_size = sz; dat_wdata = d;
    @(negedge clk);
    dat_we = 1'b0;
    chk(pos_vld === 1'b1 && pos_next === np, {req, " position"}, pos_next, np);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    chk(cyc == npix, "R12 busy slots", 32'(cyc), 32'(npix));
    @(negedge clk);
    #1;
    bad = -1;
    for (int k = 0; k < MEM; k++)
      if (bad < 0 && obs_mem[k] !== exp_mem[k]) bad = k;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " memory"}, 32'(obs_mem[bad]), 32'(exp_mem[bad]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] modes [7];
    logic [31:0] ops   [5];
    logic [2:0]  sizes [3];
    void'($urandom(32'd20240611));
    modes = '{16'h3ba0, 16'hbbe0, 16'h1360, 16'h13a0, 16'h2ea0, 16'h28a0, 16'h5a5a};
    ops   = '{32'h2300_0300, 32'h0, 32'h1000_0000, 32'h2000_0002, 32'h0000_0002};
    sizes = '{3'd1, 3'd2, 3'd4};
    for (int k = 0; k < MEM; k++) begin exp_mem[k] = 8'h00; obs_mem[k] = 8'h00; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk(pix_we === 1'b0, "R1 pix_we", 32'(pix_we), 0);
    chk(pos_vld === 1'b0, "R1 pos_vld", 32'(pos_vld), 0);
    chk(plane_mask === 32'hff, "R1 plane mask", plane_mask, 32'hff);

    // R1/R5: reset image op writes background, bitmask all ones
    reg_wr(3'd1, 32'h2ea0_0000);
    reg_wr(3'd5, 32'h0000_00c3);
    reg_wr(3'd6, 32'h0000_0044);
    data_wr("R1 R5 expand after reset", (32'd2 << XB | 32'd5) << 2, 3'd4, 32'hf00f_a55a);
    // R7 with reset gating flag
    reg_wr(3'd4, 32'h0f0f_3cc3);
    data_wr("R7 gated expand", (32'd3 << XB | 32'd0) << 2, 3'd4, 32'h1234_5678);
    data_wr("R7 gated size1", (32'd4 << XB | 32'd8) << 2, 3'd1, 32'h0000_00a5);
    data_wr("R7 gated size2", (32'd4 << XB | 32'd20) << 2, 3'd2, 32'h0000_c38e);
    reg_wr(3'd4, 32'hffff_ffff);

    // R2
    reg_wr(3'd1, 32'h3ba0_1111);
    data_wr("R2 swap A", 32'd100, 3'd4, 32'h1122_3344);
    reg_wr(3'd1, 32'hbbe0_0000);
    data_wr("R2 swap B", 32'd200, 3'd4, 32'hdead_beef);
    reg_wr(3'd4, 32'h5000_0000);
    data_wr("R7 store gated", 32'd300, 3'd4, 32'hcafe_f00d);
    reg_wr(3'd4, 32'hffff_ffff);

    // R3 / R4
    reg_wr(3'd1, 32'h1360_0000);
    data_wr("R3 xy raw", 32'd5 << XB | 32'd17, 3'd4, 32'ha1b2_c3d4);
    reg_wr(3'd1, 32'h13a0_0000);
    data_wr("R4 xy word", (32'd6 << XB | 32'd30) << 2, 3'd4, 32'h0102_0304);

    // R6
    reg_wr(3'd1, 32'h28a0_0000);
    data_wr("R6 mono", (32'd7 << XB | 32'd1) << 2, 3'd4, 32'h8001_ff00);

    // R8 both transparency flags
    reg_wr(3'd1, 32'h2ea0_0000);
    reg_wr(3'd3, 32'h1000_0000);
    data_wr("R8 transp bit28", (32'd8 << XB) << 2, 3'd4, 32'h0f0f_0f0f);
    reg_wr(3'd3, 32'h0000_0002);
    data_wr("R8 transp bit1", (32'd9 << XB) << 2, 3'd2, 32'h0000_aaaa);
    reg_wr(3'd3, 32'h2300_0300);

    // R9
    reg_wr(3'd0, 32'h3ba0_7777);
    chk(src_access === 32'h3ba0_7777, "R9 combined src", src_access, 32'h3ba0_7777);
    data_wr("R9 combined dst", 32'd400, 3'd4, 32'h5566_7788);
    reg_wr(3'd1, 32'h1360_0000);
    chk(src_access === 32'h3ba0_7777, "R9 dst only", src_access, 32'h3ba0_7777);

    // R10
    reg_wr(3'd1, 32'h1234_0000);
    data_wr("R10 unknown mode", 32'd500, 3'd4, 32'hffff_ffff);

    // R11
    reg_wr(3'd1, 32'h3ba0_0000);
    data_wr("R11 store past end", 32'(MEM - 2), 3'd4, 32'h99aa_bbcc);
    reg_wr(3'd1, 32'h2ea0_0000);
    data_wr("R11 rows off bottom", (32'(H) << XB | 32'd3) << 2, 3'd4, 32'hffff_0000);

    // random mix
    for (int t = 0; t < 200; t++) begin
      logic [15:0] m;
      logic [31:0] p;
      m = modes[$urandom_range(0, 6)];
      reg_wr(3'($urandom_range(0, 1)), {m, 16'($urandom)});
      reg_wr(3'd3, ops[$urandom_range(0, 4)]);
      reg_wr(3'd4, $urandom);
      reg_wr(3'd5, $urandom);
      reg_wr(3'd6, $urandom);
      p = 32'($urandom_range(0, H + 3)) << XB | 32'($urandom_range(0, 127));
      case (m)
        16'h3ba0, 16'hbbe0: data_wr("R2 random", 32'($urandom_range(0, MEM + 8)), 3'd4, $urandom);
        16'h1360: data_wr("R3 random", p, 3'd4, $urandom);
        16'h13a0: data_wr("R4 random", p << 2, 3'd4, $urandom);
        16'h2ea0: data_wr("R5 random", p << 2, sizes[$urandom_range(0, 2)], $urandom);
        16'h28a0: data_wr("R6 random", p << 2, sizes[$urandom_range(0, 2)], $urandom);
        default:  data_wr("R10 random", p, 3'd4, $urandom);
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule